// File: doc/BRIEF.md
# Quarter-Sine Microstep Amplitude Generator

This block turns the microstep position of one motor into two coil current amplitudes and a phase sign for each coil. Coil A follows a sine of the position and coil B follows a cosine. Both are built from one programmable table that covers a quarter of a period. The block walks the table forward in some quadrants and mirrored in others, and sets a sign bit in the two quadrants where a coil's current is negative. The amplitudes and signs are meant for the serializer that builds driver datagrams.

All motors share the table. Rewriting it therefore changes the current shape of every motor at once. Typical uses are a trapezoidal shape, or flat full-step values for running at high speed. A host port rewrites and reads the table two neighbouring entries at a time. After reset the table holds a sine-shaped default. The outputs are registered and change only when a new position is presented, so rewriting the table never disturbs them.

Top module: `qsine_amp_gen`

## Requirements
- R1: After reset, amp_a, amp_b, neg_a and neg_b are all 0. The table holds its default shape, which starts 0, 2, 3, 5 at entries 0..3 and holds 63 in entries 56 through 63.
- R2: For a position with quadrant pos[7:6] equal to 0 or 2, amp_a is the table entry at index pos[5:0].
- R3: For quadrant 1 or 3, amp_a is the table entry at the mirrored index 63 - pos[5:0].
- R4: amp_b is the value amp_a would take for the position pos + 64 (modulo 256), which is one quadrant ahead.
- R5: neg_a equals pos[7]. neg_b equals pos[7] XOR pos[6].
- R6: Outputs update on the first rising clock edge where pos_valid is high. They hold their values while pos_valid is low.
- R7: A write with tbl_wr_en high stores tbl_wr_data[5:0] into entry 2*tbl_wr_pair and tbl_wr_data[11:6] into entry 2*tbl_wr_pair+1, both in the same edge.
- R8: tbl_rd_data is registered. One clock after tbl_rd_pair is presented, it holds entry 2*pair in bits [5:0] and entry 2*pair+1 in bits [11:6].
- R9: If a table write and a position update fall on the same edge, the outputs use the contents from before the write. Later updates use the new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pos_valid | input | 1 | New position present |
| pos | input | 8 | Microstep position: quadrant in [7:6], index in [5:0] |
| tbl_wr_en | input | 1 | Write one entry pair |
| tbl_wr_pair | input | 5 | Entry pair selected for writing |
| tbl_wr_data | input | 12 | Odd entry in [11:6], even entry in [5:0] |
| tbl_rd_pair | input | 5 | Entry pair selected for reading |
| tbl_rd_data | output | 12 | Pair read one clock later, same layout |
| amp_a | output | 6 | Coil A magnitude (sine) |
| amp_b | output | 6 | Coil B magnitude (cosine) |
| neg_a | output | 1 | Coil A in its negative half period |
| neg_b | output | 1 | Coil B in its negative half period |

## Verification
A table write and a position lookup can land on the same clock edge. The two can even touch the same entry. The bench provokes this by writing the pair that holds the entry the position is about to fetch, in the very cycle pos_valid is raised. It judges the result by requiring the old magnitude on that update and the new one on the next update of the same position. Full 256-position sweeps run under two different table contents so that mirror and quadrant-offset faults become visible.

// File: rtl/qsine_pkg.sv
package qsine_pkg;

   localparam int unsigned QS_DEF_DEPTH = 64;
   localparam int unsigned QS_DEF_MAG_W = 6;

   // Default quarter-wave shape, rising to full scale
   localparam logic [5:0] QS_DEF_SHAPE [QS_DEF_DEPTH] = '{
      6'd0,  6'd2,  6'd3,  6'd5,  6'd6,  6'd8,  6'd9,  6'd11,
      6'd12, 6'd14, 6'd16, 6'd17, 6'd19, 6'd20, 6'd22, 6'd23,
      6'd24, 6'd26, 6'd27, 6'd29, 6'd30, 6'd32, 6'd33, 6'd34,
      6'd36, 6'd37, 6'd38, 6'd39, 6'd41, 6'd42, 6'd43, 6'd44,
      6'd45, 6'd46, 6'd47, 6'd48, 6'd49, 6'd50, 6'd51, 6'd52,
      6'd53, 6'd54, 6'd55, 6'd56, 6'd56, 6'd57, 6'd58, 6'd59,
      6'd59, 6'd60, 6'd60, 6'd61, 6'd61, 6'd62, 6'd62, 6'd62,
      6'd63, 6'd63, 6'd63, 6'd63, 6'd63, 6'd63, 6'd63, 6'd63
   };

   typedef enum logic [1:0] {
      QD_RISE_POS = 2'd0,
      QD_FALL_POS = 2'd1,
      QD_RISE_NEG = 2'd2,
      QD_FALL_NEG = 2'd3
   } qs_quad_e;

endpackage

// File: rtl/qsine_table.sv
module qsine_table #(
   parameter int unsigned IDX_W = 6,
   parameter int unsigned MAG_W = 6,
   parameter int unsigned N_LK  = 2
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             wr_en,
   input  logic [IDX_W-2:0]                 wr_pair,
   input  logic [2*MAG_W-1:0]               wr_data,
   input  logic [IDX_W-2:0]                 rd_pair,
   output logic [2*MAG_W-1:0]               rd_data,
   input  logic [N_LK-1:0][IDX_W-1:0]       lk_idx,
   output logic [N_LK-1:0][MAG_W-1:0]       lk_mag
);
   import qsine_pkg::*;

   localparam int unsigned DEPTH  = 1 << IDX_W;
   localparam int unsigned FULL   = (1 << MAG_W) - 1;
   localparam bit          USE_DEF = (DEPTH == QS_DEF_DEPTH) && (MAG_W == QS_DEF_MAG_W);

   if (IDX_W < 2) begin : g_chk_idx
      $error("qsine_table: IDX_W must be at least 2");
   end

   function automatic logic [MAG_W-1:0] init_val(int unsigned i);
      if (USE_DEF) return MAG_W'(QS_DEF_SHAPE[i % QS_DEF_DEPTH]);
      else         return MAG_W'((i * FULL) / (DEPTH - 1));
   endfunction

   logic [MAG_W-1:0] mag_q [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mag_q[i] <= init_val(i);
      end else if (wr_en) begin
         mag_q[{wr_pair, 1'b0}] <= wr_data[MAG_W-1:0];
         mag_q[{wr_pair, 1'b1}] <= wr_data[2*MAG_W-1:MAG_W];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rd_data <= '0;
      else        rd_data <= {mag_q[{rd_pair, 1'b1}], mag_q[{rd_pair, 1'b0}]};
   end

   for (genvar k = 0; k < N_LK; k++) begin : g_lk
      assign lk_mag[k] = mag_q[lk_idx[k]];
   end

   assert_pair_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (mag_q[{$past(wr_pair), 1'b0}] == $past(wr_data[MAG_W-1:0])) &&
                (mag_q[{$past(wr_pair), 1'b1}] == $past(wr_data[2*MAG_W-1:MAG_W])));

endmodule

// File: rtl/qsine_coil.sv
module qsine_coil #(
   parameter int unsigned POS_W = 8,
   parameter int unsigned IDX_W = 6,
   parameter int unsigned Q_OFS = 0
) (
   input  logic [POS_W-1:0] pos,
   output logic [IDX_W-1:0] idx,
   output logic             neg
);
   import qsine_pkg::*;

   if (POS_W != IDX_W + 2) begin : g_chk_w
      $error("qsine_coil: POS_W must equal IDX_W + 2");
   end

   logic [POS_W-1:0] shifted;
   qs_quad_e         quad;

   assign shifted = pos + POS_W'(Q_OFS << IDX_W);
   assign quad    = qs_quad_e'(shifted[POS_W-1 -: 2]);

   always_comb begin
      unique case (quad)
         QD_RISE_POS, QD_RISE_NEG: idx = shifted[IDX_W-1:0];
         default:                  idx = ~shifted[IDX_W-1:0];
      endcase
      neg = (quad == QD_RISE_NEG) || (quad == QD_FALL_NEG);
   end

endmodule

// File: rtl/qsine_amp_gen.sv
module qsine_amp_gen #(
   parameter int unsigned IDX_W = 6,
   parameter int unsigned MAG_W = 6,
   parameter int unsigned POS_W = IDX_W + 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 pos_valid,
   input  logic [POS_W-1:0]     pos,
   input  logic                 tbl_wr_en,
   input  logic [IDX_W-2:0]     tbl_wr_pair,
   input  logic [2*MAG_W-1:0]   tbl_wr_data,
   input  logic [IDX_W-2:0]     tbl_rd_pair,
   output logic [2*MAG_W-1:0]   tbl_rd_data,
   output logic [MAG_W-1:0]     amp_a,
   output logic [MAG_W-1:0]     amp_b,
   output logic                 neg_a,
   output logic                 neg_b
);
   localparam int unsigned N_COIL = 2;

   if (MAG_W < 1 || MAG_W > 16) begin : g_chk_mag
      $error("qsine_amp_gen: MAG_W out of range");
   end

   logic [N_COIL-1:0][IDX_W-1:0] coil_idx;
   logic [N_COIL-1:0][MAG_W-1:0] coil_mag;
   logic [N_COIL-1:0]            coil_neg;
   logic [N_COIL-1:0][MAG_W-1:0] amp_q;
   logic [N_COIL-1:0]            neg_q;

   for (genvar c = 0; c < N_COIL; c++) begin : g_coil
      qsine_coil #(.POS_W(POS_W), .IDX_W(IDX_W), .Q_OFS(c)) u_coil (
         .pos (pos),
         .idx (coil_idx[c]),
         .neg (coil_neg[c])
      );
   end

   qsine_table #(.IDX_W(IDX_W), .MAG_W(MAG_W), .N_LK(N_COIL)) u_table (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (tbl_wr_en),
      .wr_pair (tbl_wr_pair),
      .wr_data (tbl_wr_data),
      .rd_pair (tbl_rd_pair),
      .rd_data (tbl_rd_data),
      .lk_idx  (coil_idx),
      .lk_mag  (coil_mag)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         amp_q <= '0;
         neg_q <= '0;
      end else if (pos_valid) begin
         amp_q <= coil_mag;
         neg_q <= coil_neg;
      end
   end

   assign amp_a = amp_q[0];
   assign amp_b = amp_q[1];
   assign neg_a = neg_q[0];
   assign neg_b = neg_q[1];

   assert_hold_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !pos_valid |=> $stable(amp_a) && $stable(amp_b) && $stable(neg_a) && $stable(neg_b));

   assert_sign_a_R5: assert property (@(posedge clk) disable iff (!rst_n)
      pos_valid |=> neg_a == $past(pos[POS_W-1]));

   assert_sign_b_R5: assert property (@(posedge clk) disable iff (!rst_n)
      pos_valid |=> neg_b == ($past(pos[POS_W-1]) ^ $past(pos[POS_W-2])));

endmodule

// File: tb/sim_qsine_amp_gen.sv
module sim_qsine_amp_gen;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pos_valid = 1'b0;
   logic [7:0]  pos = '0;
   logic        tbl_wr_en = 1'b0;
   logic [4:0]  tbl_wr_pair = '0;
   logic [11:0] tbl_wr_data = '0;
   logic [4:0]  tbl_rd_pair = '0;
   logic [11:0] tbl_rd_data;
   logic [5:0]  amp_a, amp_b;
   logic        neg_a, neg_b;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;
   logic [5:0] model [64];

   always #2.5 clk = ~clk;

   qsine_amp_gen u0 (.*);

   task automatic chk(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int exp_amp(logic [7:0] p);
      logic [5:0] i;
      i = p[5:0];
      return p[6] ? int'(model[63 - i]) : int'(model[i]);
   endfunction

   task automatic write_pair(int pr, int lo, int hi);
      @(negedge clk);
      tbl_wr_en = 1'b1; tbl_wr_pair = 5'(pr); tbl_wr_data = {6'(hi), 6'(lo)};
      @(negedge clk);
      tbl_wr_en = 1'b0;
      model[2*pr] = 6'(lo); model[2*pr+1] = 6'(hi);
   endtask

   task automatic step_pos(logic [7:0] p);
      @(negedge clk);
      pos = p; pos_valid = 1'b1;
      @(negedge clk);
      pos_valid = 1'b0;
   endtask

   task automatic t_reset;
      chk("R1 amp_a", amp_a, 0);
      chk("R1 amp_b", amp_b, 0);
      chk("R1 neg_a", neg_a, 0);
      chk("R1 neg_b", neg_b, 0);
      @(negedge clk); tbl_rd_pair = 5'd0;
      @(negedge clk); chk("R1 default pair0", tbl_rd_data, {6'd2, 6'd0});
      tbl_rd_pair = 5'd1;
      @(negedge clk); chk("R1 default pair1", tbl_rd_data, {6'd5, 6'd3});
      tbl_rd_pair = 5'd28;
      @(negedge clk); chk("R1 default pair28", tbl_rd_data, {6'd63, 6'd63});
      tbl_rd_pair = 5'd31;
      @(negedge clk); chk("R1 default pair31", tbl_rd_data, {6'd63, 6'd63});
      step_pos(8'd64);
      chk("R1 R3 default peak amp_a", amp_a, 63);
      chk("R1 R4 default zero amp_b", amp_b, 0);
   endtask

   task automatic t_load(int kind);
      for (int pr = 0; pr < 32; pr++) begin
         if (kind == 0) write_pair(pr, 2*pr, 2*pr + 1);
         else           write_pair(pr, ((2*pr) * 37 + 11) & 63, ((2*pr + 1) * 37 + 11) & 63);
      end
   endtask

   task automatic t_readback;
      for (int pr = 0; pr < 32; pr += 7) begin
         @(negedge clk); tbl_rd_pair = 5'(pr);
         @(negedge clk);
         chk("R7 R8 readback", tbl_rd_data, {model[2*pr+1], model[2*pr]});
      end
   endtask

   task automatic t_sweep;
      int bad;
      bad = 0;
      for (int p = 0; p < 256; p++) begin
         step_pos(8'(p));
         if (amp_a != exp_amp(8'(p))) begin
            bad++;
            $display("FAIL R2 R3 pos=%0d amp_a actual=%0d expected=%0d", p, amp_a, exp_amp(8'(p)));
         end
         if (amp_b != exp_amp(8'(p + 64))) begin
            bad++;
            $display("FAIL R4 pos=%0d amp_b actual=%0d expected=%0d", p, amp_b, exp_amp(8'(p + 64)));
         end
         if (neg_a != p[7] || neg_b != (p[7] ^ p[6])) begin
            bad++;
            $display("FAIL R5 pos=%0d neg actual=%0d%0d expected=%0d%0d", p, neg_a, neg_b, p[7], p[7] ^ p[6]);
         end
      end
      checks++;
      if (bad != 0) fails++;
   endtask

   task automatic t_hold;
      step_pos(8'd200);
      @(negedge clk); pos = 8'd3;
      repeat (3) @(negedge clk);
      chk("R6 hold amp_a", amp_a, exp_amp(8'd200));
      chk("R6 hold neg_a", neg_a, 1);
      write_pair(10, 1, 2);
      chk("R6 hold across write", amp_a, exp_amp(8'd200));
   endtask

   task automatic t_collision;
      int old_v;
      old_v = int'(model[5]);
      @(negedge clk);
      pos = 8'd5; pos_valid = 1'b1;
      tbl_wr_en = 1'b1; tbl_wr_pair = 5'd2; tbl_wr_data = {6'd40, 6'd50};
      @(negedge clk);
      pos_valid = 1'b0; tbl_wr_en = 1'b0;
      model[4] = 6'd50; model[5] = 6'd40;
      chk("R9 same-edge uses old", amp_a, old_v);
      step_pos(8'd5);
      chk("R9 next update uses new", amp_a, 40);
      step_pos(8'd4);
      chk("R9 even entry new", amp_a, 50);
   endtask

   initial begin
      for (int i = 0; i < 64; i++) model[i] = 6'd0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset;
      t_load(0);
      t_readback;
      t_sweep;
      t_load(1);
      t_readback;
      t_sweep;
      t_hold;
      t_collision;
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule